// File: doc/BRIEF.md
# PCI Function Configuration Header with Base Address Decode

This block holds the 256-byte configuration space of a single PCI function. A configuration access engine reads and writes it one, two or four bytes at a time. The identity bytes are fixed by parameters and cannot be written. The command register and six base address registers can be written. A write to any other byte is accepted one byte at a time.

Each base address register has a size and a kind (I/O or memory) that are fixed when the block is built. A full dword write to a sized register is trimmed to the size alignment, and the kind bit is forced into bit 0. After such a write, or after any write that covers the command bytes, the block rebuilds its decoded windows. Each window reports its base address and a valid flag. Address decoders elsewhere on the chip use these outputs to claim transactions.

Top module: `pci_cfg_header`

## Requirements
- R1: After reset the identity bytes return their parameter values and the command register reads 0. Every base address register reads 1 if it is a sized I/O register and 0 otherwise. No window is valid, and every window base is 0.
- R2: Read data appears on the clock edge after the read address and length are presented. The length code is 00 for one byte, 01 for two bytes, and 10 or 11 for four bytes. Bytes come out little-endian: the lowest address goes in bits 7:0. Byte addresses wrap modulo 256. Unused upper bytes read 0. Four-byte accesses ignore the two low address bits.
- R3: Writes change nothing at offsets 0x00–0x03, 0x08–0x0B, 0x0E and 0x3D. Every other byte takes its lane of the write data. Lane i writes address start+i, and data bits 8i+7:8i.
- R4: A four-byte write to offset 0x10+4k, where register k has nonzero size S, stores (data AND NOT(S−1)) OR T. T is 1 for I/O and 0 for memory.
- R5: A register of size 0 stores written bytes unchanged, and its window is never valid.
- R6: A one- or two-byte write into a sized base address register stores the raw bytes. It does not rebuild the windows.
- R7: Command bit 0 gates I/O windows and command bit 1 gates memory windows. A window whose gate bit is clear is not valid.
- R8: An I/O window is invalid if its base is 0, if its last address (base+S−1) does not exceed its base, or if its last address is 0x10000 or more.
- R9: A memory window is invalid if its base is 0, if its last address does not exceed its base, or if its last address is 0xFFFFFFFF.
- R10: A write that triggers a rebuild (a four-byte sized-register write, or any write covering offset 0x04 or 0x05) is stored on clock edge N. The windows change on edge N+1 and stay unchanged otherwise.
- R11: A valid window's base equals the stored register value with its low log2(S) bits cleared. An invalid window reports base 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write start byte offset |
| wr_len | input | 2 | Write length code |
| wr_data | input | 32 | Write data, little-endian lanes |
| rd_addr | input | 8 | Read start byte offset |
| rd_len | input | 2 | Read length code |
| rd_data | output | 32 | Registered read data |
| win_base | output | 192 | Window bases, register k in bits 32k+31:32k |
| win_valid | output | 6 | Window valid flags, bit k for register k |

## Verification
Stored bytes can be read one edge after a write. Read data is due one edge after the read request. Windows keep their old value until one edge after a triggering write, and take the new value on the edge after that. The bench drives on falling edges and samples on falling edges. After each write it checks the windows against the pre-write expectation at the first falling edge, then against the rebuilt expectation at the next one. A bench model of the bytes and windows, written arithmetically from the requirements, supplies the expected values. A sweep reads back every byte, and a long sequence of mixed-length writes exercises the write path, alongside targeted boundary cases for each window rule.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  localparam int NUM_BAR = 6;
  localparam int CFG_BYTES = 256;
  localparam logic [7:0] BAR_FIRST = 8'h10;
  localparam logic [7:0] BAR_END = 8'h28;
  localparam logic [7:0] CMD_LO = 8'h04;
  localparam logic [7:0] CMD_HI = 8'h05;

  typedef struct packed {
    logic        valid;
    logic [31:0] base;
  } win_t;

  // Length code to byte count: 00 -> 1, 01 -> 2, otherwise 4.
  function automatic logic [2:0] len_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Start address of an access: dword accesses are aligned down.
  function automatic logic [7:0] access_start(input logic [7:0] a, input logic [1:0] code);
    return (len_bytes(code) == 3'd4) ? {a[7:2], 2'b00} : a;
  endfunction

  function automatic logic byte_locked(input logic [7:0] a);
    return (a <= 8'h03) || ((a >= 8'h08) && (a <= 8'h0B)) || (a == 8'h0E) || (a == 8'h3D);
  endfunction

  function automatic logic [31:0] bar_fold(input logic [31:0] value, input logic [31:0] size,
                                           input logic is_io);
    return (value & ~(size - 32'd1)) | {31'd0, is_io};
  endfunction

  function automatic win_t win_decode(input logic [31:0] bar, input logic [31:0] size,
                                      input logic is_io, input logic gate);
    logic [31:0] base;
    logic [31:0] last;
    logic        bad;
    win_t        w;
    base = bar & ~(size - 32'd1);
    last = base + size - 32'd1;
    bad  = (size == 32'd0) || !gate || (base == 32'd0) || (last <= base) ||
           (is_io ? (last >= 32'h0001_0000) : (last == 32'hFFFF_FFFF));
    w.valid = !bad;
    w.base  = bad ? 32'd0 : base;
    return w;
  endfunction

  function automatic logic [7:0] reset_byte(input logic [7:0] a, input logic [15:0] vid,
                                            input logic [15:0] did, input logic [7:0] rev,
                                            input logic [23:0] ccode, input logic [7:0] htype,
                                            input logic [7:0] pin,
                                            input logic [NUM_BAR*32-1:0] sizes,
                                            input logic [NUM_BAR-1:0] io_mask);
    logic [7:0] v;
    v = 8'h00;
    case (a)
      8'h00: v = vid[7:0];
      8'h01: v = vid[15:8];
      8'h02: v = did[7:0];
      8'h03: v = did[15:8];
      8'h08: v = rev;
      8'h09: v = ccode[7:0];
      8'h0A: v = ccode[15:8];
      8'h0B: v = ccode[23:16];
      8'h0E: v = htype;
      8'h3D: v = pin;
      default: begin
        for (int k = 0; k < NUM_BAR; k++) begin
          if (a == BAR_FIRST + 8'(4 * k))
            v = {7'd0, io_mask[k] && (sizes[32*k +: 32] != 32'd0)};
        end
      end
    endcase
    return v;
  endfunction

endpackage

// File: rtl/pcfg_write_lanes.sv
module pcfg_write_lanes
  import pcfg_pkg::*;
#(
  parameter logic [NUM_BAR*32-1:0] BAR_SIZES = '0,
  parameter logic [NUM_BAR-1:0]    BAR_IO    = '0
) (
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [1:0]  wr_len,
  input  logic [31:0] wr_data,
  output logic [3:0]  lane_en,
  output logic [31:0] lane_addr,
  output logic [31:0] lane_data,
  output logic        bar_hit,
  output logic        remap_evt
);

  logic [2:0]  nbytes;
  logic [7:0]  start;
  logic        in_bar_span;
  logic [31:0] sel_size;
  logic        sel_io;
  logic [31:0] folded;
  logic        cmd_touch;

  assign nbytes      = len_bytes(wr_len);
  assign start       = access_start(wr_addr, wr_len);
  assign in_bar_span = (nbytes == 3'd4) && (start >= BAR_FIRST) && (start < BAR_END);

  always_comb begin
    sel_size = 32'd0;
    sel_io   = 1'b0;
    for (int k = 0; k < NUM_BAR; k++) begin
      if (in_bar_span && (start == BAR_FIRST + 8'(4 * k))) begin
        sel_size = BAR_SIZES[32*k +: 32];
        sel_io   = BAR_IO[k];
      end
    end
  end

  assign bar_hit = wr_en && in_bar_span && (sel_size != 32'd0);
  assign folded  = bar_fold(wr_data, sel_size, sel_io);

  always_comb begin
    cmd_touch = 1'b0;
    for (int i = 0; i < 4; i++) begin
      lane_addr[8*i +: 8] = start + 8'(i);
      lane_data[8*i +: 8] = bar_hit ? folded[8*i +: 8] : wr_data[8*i +: 8];
      lane_en[i] = wr_en && (3'(i) < nbytes) && (bar_hit || !byte_locked(lane_addr[8*i +: 8]));
      if (wr_en && (3'(i) < nbytes) &&
          ((lane_addr[8*i +: 8] == CMD_LO) || (lane_addr[8*i +: 8] == CMD_HI)))
        cmd_touch = 1'b1;
    end
  end

  assign remap_evt = bar_hit || cmd_touch;

endmodule

// File: rtl/pcfg_byte_store.sv
module pcfg_byte_store
  import pcfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h0,
  parameter logic [15:0] DEVICE_ID   = 16'h0,
  parameter logic [7:0]  REVISION    = 8'h0,
  parameter logic [23:0] CLASS_CODE  = 24'h0,
  parameter logic [7:0]  HEADER_TYPE = 8'h0,
  parameter logic [7:0]  INT_PIN     = 8'h0,
  parameter logic [NUM_BAR*32-1:0] BAR_SIZES = '0,
  parameter logic [NUM_BAR-1:0]    BAR_IO    = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [3:0]             lane_en,
  input  logic [31:0]            lane_addr,
  input  logic [31:0]            lane_data,
  output logic [CFG_BYTES*8-1:0] cfg_flat
);

  logic [7:0] mem [CFG_BYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < CFG_BYTES; j++)
        mem[j] <= reset_byte(8'(j), VENDOR_ID, DEVICE_ID, REVISION, CLASS_CODE,
                             HEADER_TYPE, INT_PIN, BAR_SIZES, BAR_IO);
    end else begin
      for (int i = 0; i < 4; i++)
        if (lane_en[i])
          mem[lane_addr[8*i +: 8]] <= lane_data[8*i +: 8];
    end
  end

  always_comb begin
    for (int j = 0; j < CFG_BYTES; j++)
      cfg_flat[8*j +: 8] = mem[j];
  end

endmodule

// File: rtl/pcfg_bar_window.sv
module pcfg_bar_window
  import pcfg_pkg::*;
#(
  parameter logic [31:0] SIZE  = 32'd16,
  parameter logic        IS_IO = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        update,
  input  logic [31:0] bar_word,
  input  logic        cmd_io,
  input  logic        cmd_mem,
  output logic [31:0] base,
  output logic        valid
);

  win_t nxt;

  assign nxt = win_decode(bar_word, SIZE, IS_IO, IS_IO ? cmd_io : cmd_mem);

  always_ff @(posedge clk) begin
    if (rst) begin
      base  <= 32'd0;
      valid <= 1'b0;
    end else if (update) begin
      base  <= nxt.base;
      valid <= nxt.valid;
    end
  end

endmodule

// File: rtl/pcfg_read_port.sv
module pcfg_read_port
  import pcfg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CFG_BYTES*8-1:0] cfg_flat,
  input  logic [7:0]             rd_addr,
  input  logic [1:0]             rd_len,
  output logic [31:0]            rd_data
);

  logic [2:0]  nbytes;
  logic [7:0]  start;
  logic [31:0] gathered;

  assign nbytes = len_bytes(rd_len);
  assign start  = access_start(rd_addr, rd_len);

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      logic [7:0] a;
      a = start + 8'(i);
      gathered[8*i +: 8] = (3'(i) < nbytes) ? cfg_flat[{a, 3'b000} +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 32'd0;
    else     rd_data <= gathered;
  end

endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header
  import pcfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID   = 16'h5C3D,
  parameter logic [7:0]  REVISION    = 8'h03,
  parameter logic [23:0] CLASS_CODE  = 24'h020000,
  parameter logic [7:0]  HEADER_TYPE = 8'h00,
  parameter logic [7:0]  INT_PIN     = 8'h01,
  parameter logic [NUM_BAR*32-1:0] BAR_SIZES =
    {32'd0, 32'd4, 32'd16, 32'd0, 32'd4096, 32'd32},
  parameter logic [NUM_BAR-1:0] BAR_IO = 6'b010001
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [1:0]            wr_len,
  input  logic [31:0]           wr_data,
  input  logic [7:0]            rd_addr,
  input  logic [1:0]            rd_len,
  output logic [31:0]           rd_data,
  output logic [NUM_BAR*32-1:0] win_base,
  output logic [NUM_BAR-1:0]    win_valid
);

  localparam int BAR_BYTE0 = int'(BAR_FIRST);

  logic [3:0]             lane_en;
  logic [31:0]            lane_addr;
  logic [31:0]            lane_data;
  logic                   bar_hit;
  logic                   remap_evt;
  logic                   remap_q;
  logic [CFG_BYTES*8-1:0] cfg_flat;
  logic [7:0]             cmd_byte;

  pcfg_write_lanes #(.BAR_SIZES(BAR_SIZES), .BAR_IO(BAR_IO)) lanes_i (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_len    (wr_len),
    .wr_data   (wr_data),
    .lane_en   (lane_en),
    .lane_addr (lane_addr),
    .lane_data (lane_data),
    .bar_hit   (bar_hit),
    .remap_evt (remap_evt)
  );

  pcfg_byte_store #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REVISION(REVISION),
    .CLASS_CODE(CLASS_CODE), .HEADER_TYPE(HEADER_TYPE), .INT_PIN(INT_PIN),
    .BAR_SIZES(BAR_SIZES), .BAR_IO(BAR_IO)
  ) store_i (
    .clk       (clk),
    .rst       (rst),
    .lane_en   (lane_en),
    .lane_addr (lane_addr),
    .lane_data (lane_data),
    .cfg_flat  (cfg_flat)
  );

  // Rebuild request: the stored bytes settle on the write edge, the windows one edge later.
  always_ff @(posedge clk) begin
    if (rst) remap_q <= 1'b0;
    else     remap_q <= remap_evt;
  end

  assign cmd_byte = cfg_flat[8*int'(CMD_LO) +: 8];

  for (genvar k = 0; k < NUM_BAR; k++) begin : g_bar
    pcfg_bar_window #(
      .SIZE  (BAR_SIZES[32*k +: 32]),
      .IS_IO (BAR_IO[k])
    ) win_i (
      .clk      (clk),
      .rst      (rst),
      .update   (remap_q),
      .bar_word (cfg_flat[8*(BAR_BYTE0 + 4*k) +: 32]),
      .cmd_io   (cmd_byte[0]),
      .cmd_mem  (cmd_byte[1]),
      .base     (win_base[32*k +: 32]),
      .valid    (win_valid[k])
    );
  end

  pcfg_read_port rd_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_flat (cfg_flat),
    .rd_addr  (rd_addr),
    .rd_len   (rd_len),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/pci_cfg_header_chk.sv
module pci_cfg_header_chk
  import pcfg_pkg::*;
#(
  parameter logic [NUM_BAR*32-1:0] BAR_SIZES = '0,
  parameter logic [NUM_BAR-1:0]    BAR_IO    = '0
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  remap_q,
  input logic                  bar_hit,
  input logic [7:0]            cmd_byte,
  input logic [1:0]            rd_len,
  input logic [31:0]           rd_data,
  input logic [NUM_BAR*32-1:0] win_base,
  input logic [NUM_BAR-1:0]    win_valid
);

  // R10
  win_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !remap_q |=> ($stable(win_valid) && $stable(win_base)));

  // R10
  bar_rebuild_chk: assert property (@(posedge clk) disable iff (rst)
    bar_hit |=> remap_q);

  // R2
  rd_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_len == 2'b00) |=> (rd_data[31:8] == 24'd0));

  // R2
  rd_half_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_len == 2'b01) |=> (rd_data[31:16] == 16'd0));

  for (genvar k = 0; k < NUM_BAR; k++) begin : g_chk
    localparam logic [31:0] SZ = BAR_SIZES[32*k +: 32];
    if (SZ == 32'd0) begin : g_unsized
      // R5
      unsized_win_chk: assert property (@(posedge clk) disable iff (rst)
        !win_valid[k]);
    end else begin : g_sized
      // R11
      base_align_chk: assert property (@(posedge clk) disable iff (rst)
        win_valid[k] |-> ((win_base[32*k +: 32] != 32'd0) &&
                          ((win_base[32*k +: 32] & (SZ - 32'd1)) == 32'd0)));
      // R11
      invalid_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !win_valid[k] |-> (win_base[32*k +: 32] == 32'd0));
      if (BAR_IO[k]) begin : g_io
        // R7
        io_gate_chk: assert property (@(posedge clk) disable iff (rst)
          (win_valid[k] && !remap_q) |-> cmd_byte[0]);
        // R8
        io_limit_chk: assert property (@(posedge clk) disable iff (rst)
          win_valid[k] |-> (({1'b0, win_base[32*k +: 32]} + {1'b0, SZ}) <= 33'h0_0001_0000));
      end else begin : g_mem
        // R7
        mem_gate_chk: assert property (@(posedge clk) disable iff (rst)
          (win_valid[k] && !remap_q) |-> cmd_byte[1]);
        // R9
        mem_top_chk: assert property (@(posedge clk) disable iff (rst)
          win_valid[k] |-> ((win_base[32*k +: 32] + SZ - 32'd1) != 32'hFFFF_FFFF));
      end
    end
  end

endmodule

bind pci_cfg_header pci_cfg_header_chk #(.BAR_SIZES(BAR_SIZES), .BAR_IO(BAR_IO)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .remap_q   (remap_q),
  .bar_hit   (bar_hit),
  .cmd_byte  (cmd_byte),
  .rd_len    (rd_len),
  .rd_data   (rd_data),
  .win_base  (win_base),
  .win_valid (win_valid)
);

// File: tb/pci_cfg_header_tb_top.sv
module pci_cfg_header_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_addr = 8'h00;
  logic [1:0]   wr_len = 2'b00;
  logic [31:0]  wr_data = 32'd0;
  logic [7:0]   rd_addr = 8'h00;
  logic [1:0]   rd_len = 2'b00;
  logic [31:0]  rd_data;
  logic [191:0] win_base;
  logic [5:0]   win_valid;

  int errors = 0;
  int checks = 0;

  // Bench view of the default configuration.
  logic [31:0] sz [6] = '{32'd32, 32'd4096, 32'd0, 32'd16, 32'd4, 32'd0};
  bit          io [6] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  logic [7:0]  m [256];
  bit          ev [6];
  logic [31:0] eb [6];
  logic [31:0] rng = 32'h1357_9BDF;

  always #2.5 clk = ~clk;

  pci_cfg_header dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_len(wr_len),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_len(rd_len), .rd_data(rd_data),
    .win_base(win_base), .win_valid(win_valid)
  );

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic bit locked(input logic [7:0] a);
    return (a < 8'd4) || (a inside {8'd8, 8'd9, 8'd10, 8'd11, 8'd14, 8'd61});
  endfunction

  function automatic int count_of(input logic [1:0] c);
    return (c == 2'b00) ? 1 : ((c == 2'b01) ? 2 : 4);
  endfunction

  task automatic model_init();
    for (int j = 0; j < 256; j++) m[j] = 8'h00;
    m[0] = 8'h2B; m[1] = 8'h1A; m[2] = 8'h3D; m[3] = 8'h5C;
    m[8] = 8'h03; m[9] = 8'h00; m[10] = 8'h00; m[11] = 8'h02;
    m[14] = 8'h00; m[61] = 8'h01;
    for (int k = 0; k < 6; k++) if (io[k] && sz[k] != 0) m[16 + 4*k] = 8'h01;
    for (int k = 0; k < 6; k++) begin ev[k] = 0; eb[k] = 0; end
  endtask

  task automatic model_windows();
    for (int k = 0; k < 6; k++) begin
      logic [31:0] bar, b;
      longint      last;
      bit          gate, bad;
      bar = {m[19+4*k], m[18+4*k], m[17+4*k], m[16+4*k]};
      gate = io[k] ? m[4][0] : m[4][1];
      if (sz[k] == 0) bad = 1;
      else begin
        b = bar - (bar % sz[k]);
        last = longint'(b) + longint'(sz[k]) - 1;
        bad = !gate || (b == 0) || (last <= longint'(b)) ||
              (io[k] ? (last >= 64'h10000) : (last >= 64'hFFFF_FFFF));
      end
      ev[k] = !bad;
      eb[k] = bad ? 32'd0 : b;
    end
  endtask

  task automatic model_write(input logic [7:0] a0, input logic [1:0] c, input logic [31:0] d);
    int          n;
    logic [7:0]  a;
    bit          rebuild;
    int          k;
    n = count_of(c);
    a = (n == 4) ? (a0 & 8'hFC) : a0;
    rebuild = 0;
    k = (int'(a) - 16) / 4;
    if (n == 4 && a >= 16 && a < 40 && sz[k] != 0) begin
      logic [31:0] v;
      v = (d / sz[k]) * sz[k] + (io[k] ? 32'd1 : 32'd0);
      for (int i = 0; i < 4; i++) m[a + 8'(i)] = v[8*i +: 8];
      rebuild = 1;
    end else begin
      for (int i = 0; i < n; i++) begin
        logic [7:0] aa;
        aa = a + 8'(i);
        if (aa == 8'd4 || aa == 8'd5) rebuild = 1;
        if (!locked(aa)) m[aa] = d[8*i +: 8];
      end
    end
    if (rebuild) model_windows();
  endtask

  task automatic compare_windows(input string req);
    for (int k = 0; k < 6; k++) begin
      check(win_valid[k] == ev[k], req, $sformatf("window %0d valid", k),
            {31'd0, win_valid[k]}, {31'd0, ev[k]});
      check(win_base[32*k +: 32] == eb[k], req, $sformatf("window %0d base", k),
            win_base[32*k +: 32], eb[k]);
    end
  endtask

  // Entered and left at a falling edge. R10: old windows one edge after, new ones two edges after.
  task automatic do_write(input logic [7:0] a, input logic [1:0] c, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_len = c; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    compare_windows("R10");
    model_write(a, c, d);
    @(negedge clk);
    compare_windows("R7/R8/R9/R11");
  endtask

  task automatic do_read(input logic [7:0] a, input logic [1:0] c, input string req);
    logic [31:0] exp;
    int          n;
    logic [7:0]  s;
    n = count_of(c);
    s = (n == 4) ? (a & 8'hFC) : a;
    exp = 32'd0;
    for (int i = 0; i < n; i++) exp[8*i +: 8] = m[s + 8'(i)];
    rd_addr = a; rd_len = c;
    @(negedge clk);
    check(rd_data == exp, req, $sformatf("read @%02h len%0d", a, n), rd_data, exp);
  endtask

  initial begin
    model_init();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state, windows and every byte
    compare_windows("R1");
    for (int j = 0; j < 256; j++) do_read(8'(j), 2'b00, "R1");
    // R2: wide and wrapping reads
    do_read(8'hFF, 2'b01, "R2");
    do_read(8'h03, 2'b11, "R2");
    do_read(8'h0D, 2'b10, "R2");

    // R3: identity bytes stay put, neighbours take their lanes
    do_write(8'h00, 2'b10, 32'hFFFF_FFFF);
    do_write(8'h08, 2'b10, 32'hFFFF_FFFF);
    do_write(8'h3C, 2'b01, 32'h0000_AABB);
    do_write(8'h0C, 2'b10, 32'h4433_2211);
    do_read(8'h00, 2'b10, "R3");
    do_read(8'h08, 2'b10, "R3");
    do_read(8'h3C, 2'b10, "R3");
    do_read(8'h0C, 2'b10, "R3");
    check(rd_data == 32'h4400_2211, "R3", "header dword lanes", rd_data, 32'h4400_2211);

    // R4: folding of size and kind
    do_write(8'h10, 2'b10, 32'hFFFF_FFFF);
    do_read(8'h10, 2'b10, "R4");
    check(rd_data == 32'hFFFF_FFE1, "R4", "io fold", rd_data, 32'hFFFF_FFE1);
    do_write(8'h14, 2'b10, 32'hFFFF_FFFF);
    do_read(8'h14, 2'b10, "R4");
    check(rd_data == 32'hFFFF_F000, "R4", "mem fold", rd_data, 32'hFFFF_F000);

    // R5: unsized register is raw storage
    do_write(8'h18, 2'b10, 32'h1234_5678);
    do_read(8'h18, 2'b10, "R5");
    check(rd_data == 32'h1234_5678, "R5", "raw store", rd_data, 32'h1234_5678);

    // R8: I/O limits with I/O decode on
    do_write(8'h04, 2'b00, 32'h0000_0001);
    do_write(8'h10, 2'b10, 32'h0000_FFE0);
    check(win_valid[0] && win_base[31:0] == 32'h0000_FFE0, "R8", "io top fits",
          win_base[31:0], 32'h0000_FFE0);
    do_write(8'h10, 2'b10, 32'h0001_0000);
    check(!win_valid[0], "R8", "io beyond 64K", {31'd0, win_valid[0]}, 32'd0);
    do_write(8'h10, 2'b10, 32'h0000_0000);
    check(!win_valid[0], "R8", "io zero base", {31'd0, win_valid[0]}, 32'd0);
    do_write(8'h10, 2'b10, 32'h0000_1234);
    check(win_base[31:0] == 32'h0000_1220, "R11", "io masked base", win_base[31:0], 32'h0000_1220);
    do_write(8'h20, 2'b10, 32'h0000_FFFC);
    check(win_valid[4], "R8", "small io at top", {31'd0, win_valid[4]}, 32'd1);

    // R7: memory register programmed but memory decode off
    do_write(8'h14, 2'b10, 32'hFFFF_E000);
    check(!win_valid[1], "R7", "mem gated off", {31'd0, win_valid[1]}, 32'd0);
    do_write(8'h04, 2'b01, 32'h0000_0002);
    check(win_valid[1] && !win_valid[0], "R7", "swap gates", {30'd0, win_valid[1:0]}, 32'd2);

    // R9: memory top and low cases
    do_write(8'h14, 2'b10, 32'hFFFF_F000);
    check(!win_valid[1], "R9", "mem reaches top", {31'd0, win_valid[1]}, 32'd0);
    do_write(8'h14, 2'b10, 32'h0000_0ABC);
    check(!win_valid[1], "R9", "mem zero base", {31'd0, win_valid[1]}, 32'd0);
    do_write(8'h14, 2'b10, 32'hFFFF_E000);

    // R6: partial write is stored but does not move the window until the command is touched
    do_write(8'h17, 2'b00, 32'h0000_0040);
    check(win_base[63:32] == 32'hFFFF_E000, "R6", "window not rebuilt", win_base[63:32], 32'hFFFF_E000);
    do_write(8'h05, 2'b00, 32'h0000_0000);
    check(win_base[63:32] == 32'h40FF_E000, "R6", "rebuilt on command", win_base[63:32], 32'h40FF_E000);

    // Mixed sweep across the header
    for (int t = 0; t < 1500; t++) begin
      logic [7:0]  a;
      logic [1:0]  c;
      logic [31:0] d;
      rng = next_rand(rng);
      case (rng[1:0])
        2'd0: begin a = {2'b00, rng[7:2]}; c = rng[9:8]; end
        2'd1: begin a = 8'h10 + {rng[4:2] % 3'd6, 2'b00}; c = 2'b10; end
        2'd2: begin a = 8'h04; c = rng[9:8]; end
        default: begin a = rng[9:2]; c = rng[11:10]; end
      endcase
      rng = next_rand(rng);
      d = rng[0] ? (rng & 32'h0001_FFFF) : rng;
      do_write(a, c, d);
    end
    for (int j = 0; j < 64; j++) do_read(8'(4 * j), 2'b10, "R3");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule